// File: doc/BRIEF.md
# Port Input Function and Interrupt Router

This block sits between four port input pins and the CPU's interrupt controller. Each pin passes through a multi-flop synchronizer. A three-bit port mode word, an eight-bit UART control word, a receive-interrupt enable and a two-bit edge-select field then decide three things. The first is the value the CPU sees when it reads each port bit. The second is which source drives each of the three interrupt request lines. The third is which pins may still qualify as stop-mode wake-up sources.

Two comparator outputs and an IR amplifier output also pass through the synchronizer. While the stop input is high they are held at their last value, so a powered-down analog front end cannot raise a request. UART receive, transmit-empty and baud-generator events arrive as one-cycle pulses in the clock domain. The selected level sources go through an edge detector, and every interrupt line leaves the block as a registered one-cycle pulse.

Top module: `pin_irq_router`

## Requirements
- R1: With mode bit 1 (analog) set, read bit 0 is 1 whatever pin 0 is; with it clear, read bit 0 follows the synchronized pin 0.
- R2: The pin-1 function is the IR amplifier when mode bits 2 and 1 are both set, comparator 1 when only bit 1 is set, and pin 1 otherwise; read bit 1 and interrupt line 2 both use that function.
- R3: Edge select 00 detects falling edges, 01 rising edges, and 10 or 11 both edges, on interrupt lines 0 and 2.
- R4: Interrupt line 0 comes from pin 2 in digital mode and from comparator 2 in analog mode; when the receive-interrupt enable is high, the UART receive event drives it instead and pin edges are ignored.
- R5: In analog mode read bit 3 is 0 when a stop-recovery condition is present and 1 when none is; in digital mode it follows pin 3; read bit 2 follows comparator 2 in analog mode and pin 2 otherwise.
- R6: With no UART source selected, a falling edge of pin 3 raises interrupt line 1 in digital mode and a rising edge never does; in analog mode pin 3 never raises it.
- R7: UART control bits 7 and 5 both set select the transmit-empty event for line 1; otherwise bits 0 and 5 set with bit 6 clear select the baud-generator event; a selected UART source blocks pin 3 and the other event.
- R8: With UART control bit 6 set the UART receive output follows synchronized pin 2; with it clear the output sits at the idle level 1.
- R9: The wake-enable output equals the wake mask, except that pins 1 and 2 are forced to 0 in analog mode.
- R10: While stop is high the comparator and IR outputs are frozen: toggling them raises no interrupt and read bit 1 keeps its value.
- R11: After reset every interrupt line is 0, and each detected event gives a pulse exactly one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 4 | Asynchronous port pins 0 to 3 |
| cmp1_i | input | 1 | Comparator 1 output |
| cmp2_i | input | 1 | Comparator 2 output |
| ir_amp_i | input | 1 | IR amplifier output |
| stop_i | input | 1 | Stop mode active, freezes analog outputs |
| rx_evt_i | input | 1 | UART receive event pulse |
| txe_evt_i | input | 1 | UART transmit-shift-empty event pulse |
| brg_evt_i | input | 1 | Baud-generator event pulse |
| rxie_i | input | 1 | UART receive interrupt enable |
| smr_cond_i | input | 1 | Stop-recovery condition present |
| pm_i | input | 3 | Port mode: bit 1 analog, bit 2 IR select |
| uc_i | input | 8 | UART control: bits 7, 6, 5, 0 used |
| edge_sel_i | input | 2 | Edge select for lines 0 and 2 |
| wake_mask_i | input | 4 | Pins requested as wake-up sources |
| rd_o | output | 4 | Value returned on a port read |
| uart_rx_o | output | 1 | UART receive input |
| wake_en_o | output | 4 | Qualified wake-up sources |
| irq_o | output | 3 | Interrupt request pulses, lines 0 to 2 |

## Verification
Random combinations of mode word, control word, pin levels, analog levels and stop-recovery flag exercise the read path, receive routing and wake qualifier. These show whether each mode bit's priority is honoured for every pin at once. Directed edge sequences toggle one source at a time and count pulses on all three lines. Rising against falling transitions test the edge-select encodings. Toggling a deselected source shows that the wrong source is blocked. Events applied with both UART conditions true show which line-1 source wins. Toggling the analog outputs during stop shows whether they are frozen.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
   localparam int PM_ANA    = 1;
   localparam int PM_IR     = 2;
   localparam int UC_BRG    = 0;
   localparam int UC_IEN    = 5;
   localparam int UC_RXSEL  = 6;
   localparam int UC_TXE    = 7;
   localparam int N_PINS    = 4;
   localparam int N_ANA     = 3;
   localparam int N_IRQ     = 3;

   typedef enum logic [1:0] {
      EDGE_FALL = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_ANY  = 2'b10
   } edge_e;

   typedef enum logic [1:0] {
      L1_NONE,
      L1_TXE,
      L1_BRG,
      L1_PIN
   } l1_src_e;

   function automatic logic edge_hit(input logic [1:0] sel, input logic cur, input logic prev);
      case (sel)
         2'b00:   return prev & ~cur;
         2'b01:   return ~prev & cur;
         default: return prev ^ cur;
      endcase
   endfunction
endpackage

// File: rtl/pir_sync.sv
module pir_sync #(
   parameter int W      = 7,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= '0;
      end else begin
         stg[0] <= d_i;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pir_edge.sv
module pir_edge (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       lvl_i,
   input  logic [1:0] sel_i,
   output logic       hit_o
);
   import pin_irq_pkg::*;

   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl_i;
   end

   assign hit_o = edge_hit(sel_i, lvl_i, prev_q);
endmodule

// File: rtl/pir_route.sv
module pir_route #(
   parameter logic RX_IDLE = 1'b1
) (
   input  logic                       ana_mode_i,
   input  logic                       ir_sel_i,
   input  logic [pin_irq_pkg::N_PINS-1:0] pin_s_i,
   input  logic                       cmp1_i,
   input  logic                       cmp2_i,
   input  logic                       ir_i,
   input  logic                       smr_cond_i,
   input  logic [7:0]                 uc_i,
   input  logic [pin_irq_pkg::N_PINS-1:0] wake_mask_i,
   output logic [pin_irq_pkg::N_PINS-1:0] rd_o,
   output logic                       uart_rx_o,
   output logic [pin_irq_pkg::N_PINS-1:0] wake_en_o,
   output logic                       lvl0_o,
   output logic                       lvl2_o,
   output pin_irq_pkg::l1_src_e       l1_src_o
);
   import pin_irq_pkg::*;

   logic f1;
   logic f2;
   logic txe_cond;
   logic brg_cond;
   logic [N_PINS-1:0] ana_block;

   always_comb begin
      if (ana_mode_i && ir_sel_i) f1 = ir_i;
      else if (ana_mode_i)        f1 = cmp1_i;
      else                        f1 = pin_s_i[1];
   end

   assign f2 = ana_mode_i ? cmp2_i : pin_s_i[2];

   assign rd_o[0] = ana_mode_i ? 1'b1 : pin_s_i[0];
   assign rd_o[1] = f1;
   assign rd_o[2] = f2;
   assign rd_o[3] = ana_mode_i ? ~smr_cond_i : pin_s_i[3];

   assign uart_rx_o = uc_i[UC_RXSEL] ? pin_s_i[2] : RX_IDLE;

   assign ana_block = ana_mode_i ? 4'b0110 : 4'b0000;
   assign wake_en_o = wake_mask_i & ~ana_block;

   assign lvl0_o = f2;
   assign lvl2_o = f1;

   assign txe_cond = uc_i[UC_TXE] & uc_i[UC_IEN];
   assign brg_cond = uc_i[UC_BRG] & uc_i[UC_IEN] & ~uc_i[UC_RXSEL];

   always_comb begin
      if (txe_cond)        l1_src_o = L1_TXE;
      else if (brg_cond)   l1_src_o = L1_BRG;
      else if (!ana_mode_i) l1_src_o = L1_PIN;
      else                 l1_src_o = L1_NONE;
   end

   logic unused_uc;
   assign unused_uc = ^uc_i[4:1];
endmodule

// File: rtl/pin_irq_router.sv
module pin_irq_router #(
   parameter int   SYNC_STAGES = 2,
   parameter logic RX_IDLE     = 1'b1,
   parameter logic ANA_RST     = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] pin_i,
   input  logic       cmp1_i,
   input  logic       cmp2_i,
   input  logic       ir_amp_i,
   input  logic       stop_i,
   input  logic       rx_evt_i,
   input  logic       txe_evt_i,
   input  logic       brg_evt_i,
   input  logic       rxie_i,
   input  logic       smr_cond_i,
   input  logic [2:0] pm_i,
   input  logic [7:0] uc_i,
   input  logic [1:0] edge_sel_i,
   input  logic [3:0] wake_mask_i,
   output logic [3:0] rd_o,
   output logic       uart_rx_o,
   output logic [3:0] wake_en_o,
   output logic [2:0] irq_o
);
   import pin_irq_pkg::*;

   localparam int SYNC_W = N_PINS + N_ANA;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_W-1:0] raw;
   logic [SYNC_W-1:0] synced;
   logic [N_PINS-1:0] pin_s;
   logic [N_ANA-1:0]  ana_s;
   logic [N_ANA-1:0]  ana_eff;
   logic [N_ANA-1:0]  ana_hold;

   assign raw = {ir_amp_i, cmp2_i, cmp1_i, pin_i};

   pir_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw),
      .q_o   (synced)
   );

   assign pin_s = synced[N_PINS-1:0];
   assign ana_s = synced[SYNC_W-1:N_PINS];

   assign ana_eff = stop_i ? ana_hold : ana_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ana_hold <= {N_ANA{ANA_RST}};
      else        ana_hold <= ana_eff;
   end

   logic    lvl0;
   logic    lvl2;
   l1_src_e l1_src;

   pir_route #(.RX_IDLE(RX_IDLE)) u_route (
      .ana_mode_i  (pm_i[PM_ANA]),
      .ir_sel_i    (pm_i[PM_IR]),
      .pin_s_i     (pin_s),
      .cmp1_i      (ana_eff[0]),
      .cmp2_i      (ana_eff[1]),
      .ir_i        (ana_eff[2]),
      .smr_cond_i  (smr_cond_i),
      .uc_i        (uc_i),
      .wake_mask_i (wake_mask_i),
      .rd_o        (rd_o),
      .uart_rx_o   (uart_rx_o),
      .wake_en_o   (wake_en_o),
      .lvl0_o      (lvl0),
      .lvl2_o      (lvl2),
      .l1_src_o    (l1_src)
   );

   logic [N_IRQ-1:0] det_lvl;
   logic [1:0]       det_sel [N_IRQ];
   logic [N_IRQ-1:0] det_hit;

   assign det_lvl    = {lvl2, pin_s[3], lvl0};
   assign det_sel[0] = edge_sel_i;
   assign det_sel[1] = EDGE_FALL;
   assign det_sel[2] = edge_sel_i;

   generate
      for (genvar k = 0; k < N_IRQ; k++) begin : g_det
         pir_edge u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .lvl_i (det_lvl[k]),
            .sel_i (det_sel[k]),
            .hit_o (det_hit[k])
         );
      end
   endgenerate

   logic [N_IRQ-1:0] irq_d;

   always_comb begin
      irq_d[0] = rxie_i ? rx_evt_i : det_hit[0];
      case (l1_src)
         L1_TXE:  irq_d[1] = txe_evt_i;
         L1_BRG:  irq_d[1] = brg_evt_i;
         L1_PIN:  irq_d[1] = det_hit[1];
         default: irq_d[1] = 1'b0;
      endcase
      irq_d[2] = det_hit[2];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_o <= '0;
      else        irq_o <= irq_d;
   end
endmodule

// File: rtl/pin_irq_router_chk.sv
module pin_irq_router_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] pm_i,
   input logic [7:0] uc_i,
   input logic       rxie_i,
   input logic       rx_evt_i,
   input logic       txe_evt_i,
   input logic       smr_cond_i,
   input logic [3:0] rd_o,
   input logic       uart_rx_o,
   input logic [3:0] wake_en_o,
   input logic [2:0] irq_o
);
   // R1
   a_r1_bit0_analog: assert property (@(posedge clk) disable iff (!rst_n)
      pm_i[1] |-> rd_o[0]);
   // R5
   a_r5_smr_read: assert property (@(posedge clk) disable iff (!rst_n)
      (pm_i[1] && smr_cond_i) |-> !rd_o[3]);
   // R8
   a_r8_rx_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !uc_i[6] |-> uart_rx_o);
   // R9
   a_r9_wake_block: assert property (@(posedge clk) disable iff (!rst_n)
      pm_i[1] |-> (!wake_en_o[1] && !wake_en_o[2]));
   // R7
   a_r7_txe_route: assert property (@(posedge clk) disable iff (!rst_n)
      (uc_i[7] && uc_i[5] && txe_evt_i) |=> irq_o[1]);
   // R4
   a_r4_rx_route: assert property (@(posedge clk) disable iff (!rst_n)
      (rxie_i && rx_evt_i) |=> irq_o[0]);
endmodule

bind pin_irq_router pin_irq_router_chk u_chk (.*);

// File: tb/test_pin_irq_router.sv
module test_pin_irq_router;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] pin_i = '0;
   logic       cmp1_i = 1'b0, cmp2_i = 1'b0, ir_amp_i = 1'b0, stop_i = 1'b0;
   logic       rx_evt_i = 1'b0, txe_evt_i = 1'b0, brg_evt_i = 1'b0;
   logic       rxie_i = 1'b0, smr_cond_i = 1'b0;
   logic [2:0] pm_i = '0;
   logic [7:0] uc_i = '0;
   logic [1:0] edge_sel_i = '0;
   logic [3:0] wake_mask_i = '0;
   logic [3:0] rd_o;
   logic       uart_rx_o;
   logic [3:0] wake_en_o;
   logic [2:0] irq_o;

   int n_run = 0;
   int n_fail = 0;
   int c0, c1, c2;
   int longest = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pin_irq_router i_pin_irq_router (.*);

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic count(input int n);
      int run = 0;
      c0 = 0; c1 = 0; c2 = 0;
      for (int i = 0; i < n; i++) begin
         c0 += irq_o[0]; c1 += irq_o[1]; c2 += irq_o[2];
         if (irq_o != 3'b000) run++; else run = 0;
         if (run > longest) longest = run;
         @(negedge clk);
      end
   endtask

   task automatic expect3(input string req, input int e0, input int e1, input int e2);
      check(c0 == e0 && c1 == e1 && c2 == e2, req, c2*100 + c1*10 + c0, e2*100 + e1*10 + e0);
   endtask

   task automatic drain();
      repeat (8) @(negedge clk);
   endtask

   function automatic logic [3:0] exp_rd(input logic [2:0] pm, input logic [3:0] p,
                                         input logic c1, input logic c2, input logic ir,
                                         input logic smr);
      logic [3:0] r;
      logic ana = pm[1];
      r[0] = ana ? 1'b1 : p[0];
      r[1] = (ana && pm[2]) ? ir : (ana ? c1 : p[1]);
      r[2] = ana ? c2 : p[2];
      r[3] = ana ? ~smr : p[3];
      return r;
   endfunction

   function automatic logic [3:0] exp_wake(input logic [2:0] pm, input logic [3:0] m);
      return pm[1] ? (m & 4'b1001) : m;
   endfunction

   // pulse one event line for one cycle, then count from the next sample
   task automatic fire(input int which);
      case (which)
         0: rx_evt_i = 1'b1;
         1: txe_evt_i = 1'b1;
         default: brg_evt_i = 1'b1;
      endcase
      @(negedge clk);
      rx_evt_i = 1'b0; txe_evt_i = 1'b0; brg_evt_i = 1'b0;
      count(6);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check(irq_o == 3'b000, "R11 reset irq", irq_o, 0);
      drain();

      // R3 edge select on line 0 (pin 2, digital)
      edge_sel_i = 2'b00;
      pin_i[2] = 1'b1; count(7); expect3("R3 fall sel, rising pin2", 0, 0, 0);
      pin_i[2] = 1'b0; count(7); expect3("R3 fall sel, falling pin2", 1, 0, 0);
      edge_sel_i = 2'b01;
      pin_i[2] = 1'b1; count(7); expect3("R3 rise sel, rising pin2", 1, 0, 0);
      pin_i[2] = 1'b0; count(7); expect3("R3 rise sel, falling pin2", 0, 0, 0);
      edge_sel_i = 2'b11;
      pin_i[2] = 1'b1; count(7); expect3("R3 any sel 11, rising pin2", 1, 0, 0);
      pin_i[2] = 1'b0; count(7); expect3("R3 any sel 11, falling pin2", 1, 0, 0);
      edge_sel_i = 2'b10;
      pin_i[1] = 1'b1; count(7); expect3("R3 any sel 10, rising pin1 on line2", 0, 0, 1);
      pin_i[1] = 1'b0; count(7); expect3("R3 any sel 10, falling pin1 on line2", 0, 0, 1);

      // R2 pin-1 function priority
      pm_i = 3'b110; drain();
      ir_amp_i = 1'b1; count(7); expect3("R2 IR selected, IR toggles", 0, 0, 1);
      check(rd_o[1] == 1'b1, "R2 read bit1 is IR", rd_o[1], 1);
      cmp1_i = 1'b1; pin_i[1] = 1'b1; count(7); expect3("R2 IR selected, cmp1/pin1 ignored", 0, 0, 0);
      ir_amp_i = 1'b0; count(7); expect3("R2 IR selected, IR falls", 0, 0, 1);
      cmp1_i = 1'b0; pin_i[1] = 1'b0; drain();
      pm_i = 3'b010; drain();
      cmp1_i = 1'b1; count(7); expect3("R2 cmp1 selected", 0, 0, 1);
      ir_amp_i = 1'b1; count(7); expect3("R2 cmp1 selected, IR ignored", 0, 0, 0);
      cmp1_i = 1'b0; ir_amp_i = 1'b0; drain();
      pm_i = 3'b100; drain();
      pin_i[1] = 1'b1; count(7); expect3("R2 bit2 alone keeps pin1 digital", 0, 0, 1);
      ir_amp_i = 1'b1; count(7); expect3("R2 bit2 alone, IR ignored", 0, 0, 0);
      pin_i[1] = 1'b0; ir_amp_i = 1'b0; drain();

      // R4 line-0 source
      pm_i = 3'b010; drain();
      cmp2_i = 1'b1; count(7); expect3("R4 analog cmp2 drives line0", 1, 0, 0);
      pin_i[2] = 1'b1; count(7); expect3("R4 analog pin2 ignored", 0, 0, 0);
      cmp2_i = 1'b0; pin_i[2] = 1'b0; drain();
      pm_i = 3'b000; rxie_i = 1'b1; drain();
      fire(0); expect3("R4 rx event drives line0", 1, 0, 0);
      pin_i[2] = 1'b1; count(7); expect3("R4 rx enabled, pin2 ignored", 0, 0, 0);
      pin_i[2] = 1'b0; rxie_i = 1'b0; drain();

      // R6 pin 3 on line 1
      pin_i[3] = 1'b1; count(7); expect3("R6 pin3 rising ignored", 0, 0, 0);
      pin_i[3] = 1'b0; count(7); expect3("R6 pin3 falling raises line1", 0, 1, 0);
      pin_i[3] = 1'b1; drain();
      pm_i = 3'b010; drain();
      pin_i[3] = 1'b0; count(7); expect3("R6 analog pin3 falling ignored", 0, 0, 0);
      pm_i = 3'b000; drain();

      // R7 UART sources for line 1
      uc_i = 8'b1010_0000; drain();
      fire(1); expect3("R7 txe selected", 0, 1, 0);
      fire(2); expect3("R7 txe selected, brg blocked", 0, 0, 0);
      pin_i[3] = 1'b1; drain();
      pin_i[3] = 1'b0; count(7); expect3("R7 txe selected, pin3 blocked", 0, 0, 0);
      uc_i = 8'b0010_0001; drain();
      fire(2); expect3("R7 brg selected", 0, 1, 0);
      fire(1); expect3("R7 brg selected, txe blocked", 0, 0, 0);
      uc_i = 8'b0110_0001; drain();
      fire(2); expect3("R7 brg needs bit6 clear", 0, 0, 0);
      pin_i[3] = 1'b1; drain();
      pin_i[3] = 1'b0; count(7); expect3("R7 no UART source, pin3 fallback", 0, 1, 0);
      uc_i = 8'b1010_0001; drain();
      fire(1); expect3("R7 both true, txe wins", 0, 1, 0);
      fire(2); expect3("R7 both true, brg loses", 0, 0, 0);
      uc_i = 8'h00; drain();

      // R10 stop freezes analog outputs
      pm_i = 3'b010; edge_sel_i = 2'b10; drain();
      stop_i = 1'b1; drain();
      cmp1_i = 1'b1; cmp2_i = 1'b1; count(7); expect3("R10 stop blocks cmp edges", 0, 0, 0);
      check(rd_o[1] == 1'b0, "R10 read bit1 frozen", rd_o[1], 0);
      stop_i = 1'b0; drain();
      cmp1_i = 1'b0; cmp2_i = 1'b0; drain();
      pm_i = 3'b000; drain();

      // R11 pulse width
      check(longest == 1, "R11 one-cycle pulses", longest, 1);

      // R1 R5 R8 R9 random configurations
      for (int it = 0; it < 150; it++) begin
         logic [3:0] er;
         @(negedge clk);
         pin_i = 4'($urandom); cmp1_i = 1'($urandom); cmp2_i = 1'($urandom);
         ir_amp_i = 1'($urandom); pm_i = 3'($urandom); uc_i = 8'($urandom);
         smr_cond_i = 1'($urandom); wake_mask_i = 4'($urandom); rxie_i = 1'($urandom);
         edge_sel_i = 2'($urandom);
         repeat (4) @(negedge clk);
         er = exp_rd(pm_i, pin_i, cmp1_i, cmp2_i, ir_amp_i, smr_cond_i);
         check(rd_o[0] == er[0], "R1 read bit0", rd_o[0], er[0]);
         check(rd_o[1] == er[1], "R2 read bit1", rd_o[1], er[1]);
         check(rd_o[3:2] == er[3:2], "R5 read bits3:2", rd_o[3:2], er[3:2]);
         check(uart_rx_o == (uc_i[6] ? pin_i[2] : 1'b1), "R8 uart rx", uart_rx_o,
               uc_i[6] ? pin_i[2] : 1'b1);
         check(wake_en_o == exp_wake(pm_i, wake_mask_i), "R9 wake qualifier", wake_en_o,
               exp_wake(pm_i, wake_mask_i));
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule